// File: doc/BRIEF.md
# Data-Operation Execute and Fetch Sequencer

This block drives the execute stage of a small pipelined processor for register-to-register data operations. The decode stage presents one decoded instruction at a time: its operation class, whether the shift amount comes from a register, the destination register and whether a result is to be written. The block then steps through the execute cycles that instruction needs. In each cycle it produces the instruction-fetch request, the data-bus cycle type, the register-file read and write enables, a pipeline flush and an exception-lockout flag. It also returns a busy signal that holds the decode stage until the instruction's final cycle.

An operation with an immediate or constant shift finishes in one cycle. In that cycle it prefetches the next instruction sequentially from three instruction widths past the current program counter. A register-specified shift adds a second execute cycle, which reads the shift amount and issues no fetch. A write to the program counter flushes the pipeline and fetches the ALU result non-sequentially. Two sequential refill fetches follow. Exception entry is locked out from the flush until the refill finishes. The instruction width is 4 bytes in the 32-bit state and 2 bytes in the 16-bit state.

Top module: `dataop_seq`

## Requirements
- R1: After reset, with no instruction issued, `busy`, `flush`, `exc_lock`, `fetch_req` and `rf_wr_en` are all 0.
- R2: An issued operation without a register shift and without a program-counter destination completes in its issue cycle. In that cycle `fetch_req`=1, `fetch_seq`=1, `fetch_addr` = `pc_in` + 3 × width and `busy`=0.
- R3: The instruction width is 4 when `half_width`=0 and 2 when `half_width`=1.
- R4: Operation classes compare (`op_class`=2'b10) and test (2'b11) never assert `rf_wr_en` and never cause a flush, whatever `wr_result` and `dest_reg` are. Classes arithmetic (2'b00) and move (2'b01) write register `dest_reg` in their final cycle when `wr_result`=1.
- R5: A register-shifted operation takes two cycles. The first fetches sequentially from `pc_in` + 3 × width, with `busy`=1 and `rf_wr_en`=0. The second has `fetch_req`=0, `rf_rd_shift`=1 and `busy`=0, and performs the register write.
- R6: A written result whose destination is register 15 (the program counter) asserts `flush` for one cycle. In that cycle `fetch_addr` = `alu_result`, `fetch_seq`=0 and `rf_wr_en`=0.
- R7: In the two cycles after a flush, the block fetches sequentially from target + width and then from target + 2 × width. `busy` is 1 and then 0, and any instruction presented during those cycles is ignored.
- R8: `exc_lock` is 1 in the flush cycle and in both refill cycles, and 0 otherwise.
- R9: `dbus_cyc` shows the idle code 2'b00 in every cycle.
- R10: A register-shifted operation with a program-counter destination flushes in its second cycle, using the `alu_result` present in that cycle as the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Decoded instruction presented |
| op_class | input | 2 | 00 arithmetic, 01 move, 10 compare, 11 test |
| shift_by_reg | input | 1 | Shift amount taken from a register |
| dest_reg | input | 4 | Destination register index (15 = program counter) |
| wr_result | input | 1 | Instruction writes its result |
| half_width | input | 1 | 16-bit instruction state |
| pc_in | input | 32 | Current program counter |
| alu_result | input | 32 | ALU result of the current cycle |
| fetch_addr | output | 32 | Instruction fetch address |
| fetch_req | output | 1 | Instruction fetch this cycle |
| fetch_seq | output | 1 | Fetch is sequential (0 = non-sequential) |
| dbus_cyc | output | 2 | Data-bus cycle type (00 idle) |
| rf_rd_en | output | 1 | Operand read from register file |
| rf_rd_shift | output | 1 | Shift-amount register read |
| rf_wr_en | output | 1 | Register-file write |
| rf_wr_addr | output | 4 | Register-file write index |
| flush | output | 1 | Invalidate instruction pipeline |
| exc_lock | output | 1 | Exception entry blocked |
| busy | output | 1 | Stall decode; not the final cycle |

## Verification
All outputs are combinational from the current state and the inputs. The result of the issue cycle is therefore due in that same cycle. A second shift cycle is due one clock later, and the refill fetches are due one and two clocks after the flush. The bench changes inputs at the falling edge and samples 1 ns later, well before the next rising edge. Each step of a multi-cycle sequence is checked in the cycle in which it is due. After the last refill cycle, one further cycle is checked to confirm that the lockout has cleared.

// File: rtl/dataop_seq_pkg.sv
package dataop_seq_pkg;

    typedef enum logic [1:0] {
        ST_EXEC    = 2'b00,
        ST_SHIFT2  = 2'b01,
        ST_REFILL1 = 2'b10,
        ST_REFILL2 = 2'b11
    } seq_state_t;

    typedef enum logic [1:0] {
        OPC_ARITH = 2'b00,
        OPC_MOVE  = 2'b01,
        OPC_CMP   = 2'b10,
        OPC_TST   = 2'b11
    } op_class_t;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'b00,
        BUS_NSEQ = 2'b01,
        BUS_SEQ  = 2'b10
    } bus_cyc_t;

    typedef enum logic [2:0] {
        FS_NONE   = 3'd0,
        FS_NEXT   = 3'd1,
        FS_TARGET = 3'd2,
        FS_REF1   = 3'd3,
        FS_REF2   = 3'd4
    } fetch_sel_t;

    typedef struct packed {
        fetch_sel_t sel;
        logic       busy;
        logic       exc_lock;
        logic       flush;
        logic       wr_slot;
        logic       rd_ops;
        logic       rd_shift;
    } seq_ctl_t;

    // bytes per instruction in the selected state
    function automatic logic [2:0] instr_bytes(input logic half);
        return half ? 3'd2 : 3'd4;
    endfunction

    // class produces a register result
    function automatic logic class_writes(input op_class_t c, input logic wr);
        return wr && ((c == OPC_ARITH) || (c == OPC_MOVE));
    endfunction

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import dataop_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue_valid,
    input  logic       shift_by_reg,
    input  logic       cur_writes_pc,
    output seq_state_t state,
    output seq_ctl_t   ctl
);

    seq_state_t state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EXEC;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt    = state;
        ctl          = '0;
        ctl.sel      = FS_NONE;
        unique case (state)
            ST_EXEC: begin
                if (issue_valid) begin
                    ctl.rd_ops = 1'b1;
                    if (shift_by_reg) begin
                        ctl.sel   = FS_NEXT;
                        ctl.busy  = 1'b1;
                        state_nxt = ST_SHIFT2;
                    end else if (cur_writes_pc) begin
                        ctl.sel      = FS_TARGET;
                        ctl.flush    = 1'b1;
                        ctl.exc_lock = 1'b1;
                        ctl.busy     = 1'b1;
                        state_nxt    = ST_REFILL1;
                    end else begin
                        ctl.sel     = FS_NEXT;
                        ctl.wr_slot = 1'b1;
                    end
                end
            end
            ST_SHIFT2: begin
                ctl.rd_ops   = 1'b1;
                ctl.rd_shift = 1'b1;
                if (cur_writes_pc) begin
                    ctl.sel      = FS_TARGET;
                    ctl.flush    = 1'b1;
                    ctl.exc_lock = 1'b1;
                    ctl.busy     = 1'b1;
                    state_nxt    = ST_REFILL1;
                end else begin
                    ctl.wr_slot = 1'b1;
                    state_nxt   = ST_EXEC;
                end
            end
            ST_REFILL1: begin
                ctl.sel      = FS_REF1;
                ctl.exc_lock = 1'b1;
                ctl.busy     = 1'b1;
                state_nxt    = ST_REFILL2;
            end
            ST_REFILL2: begin
                ctl.sel      = FS_REF2;
                ctl.exc_lock = 1'b1;
                state_nxt    = ST_EXEC;
            end
            default: state_nxt = ST_EXEC;
        endcase
    end

endmodule

// File: rtl/seq_rf_ctl.sv
module seq_rf_ctl
    import dataop_seq_pkg::*;
#(
    parameter int REG_AW = 4,
    parameter int PC_IDX = 15
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              from_latch,
    input  op_class_t         op_class,
    input  logic              wr_result,
    input  logic [REG_AW-1:0] dest_reg,
    output logic              cur_writes_pc,
    output logic              cur_writes_gpr,
    output logic [REG_AW-1:0] cur_dest
);

    localparam logic [REG_AW-1:0] PC_SEL = PC_IDX[REG_AW-1:0];

    op_class_t         opc_q;
    logic              wr_q;
    logic [REG_AW-1:0] dst_q;
    op_class_t         opc_c;
    logic              wr_c;
    logic              writes;

    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q <= OPC_CMP;
            wr_q  <= 1'b0;
            dst_q <= '0;
        end else if (capture) begin
            opc_q <= op_class;
            wr_q  <= wr_result;
            dst_q <= dest_reg;
        end
    end

    always_comb begin
        opc_c          = from_latch ? opc_q : op_class;
        wr_c           = from_latch ? wr_q  : wr_result;
        cur_dest       = from_latch ? dst_q : dest_reg;
        writes         = class_writes(opc_c, wr_c);
        cur_writes_pc  = writes && (cur_dest == PC_SEL);
        cur_writes_gpr = writes && (cur_dest != PC_SEL);
    end

endmodule

// File: rtl/seq_fetch_gen.sv
module seq_fetch_gen
    import dataop_seq_pkg::*;
#(
    parameter int XLEN = 32
)(
    input  logic            clk,
    input  logic            rst,
    input  fetch_sel_t      sel,
    input  logic            half_width,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] alu_result,
    output logic [XLEN-1:0] fetch_addr,
    output logic            fetch_req,
    output logic            fetch_seq
);

    logic [XLEN-1:0] tgt_q;
    logic [XLEN-1:0] step_q;
    logic [XLEN-1:0] step_now;

    assign step_now = XLEN'(instr_bytes(half_width));

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= '0;
            step_q <= XLEN'(4);
        end else if (sel == FS_TARGET) begin
            tgt_q  <= alu_result;
            step_q <= step_now;
        end
    end

    always_comb begin
        fetch_addr = '0;
        fetch_req  = 1'b0;
        fetch_seq  = 1'b0;
        unique case (sel)
            FS_NEXT: begin
                fetch_addr = pc_in + step_now + (step_now << 1);
                fetch_req  = 1'b1;
                fetch_seq  = 1'b1;
            end
            FS_TARGET: begin
                fetch_addr = alu_result;
                fetch_req  = 1'b1;
            end
            FS_REF1: begin
                fetch_addr = tgt_q + step_q;
                fetch_req  = 1'b1;
                fetch_seq  = 1'b1;
            end
            FS_REF2: begin
                fetch_addr = tgt_q + (step_q << 1);
                fetch_req  = 1'b1;
                fetch_seq  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dataop_seq.sv
module dataop_seq
    import dataop_seq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 4,
    parameter int PC_IDX = 15
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [1:0]        op_class,
    input  logic              shift_by_reg,
    input  logic [REG_AW-1:0] dest_reg,
    input  logic              wr_result,
    input  logic              half_width,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   alu_result,
    output logic [XLEN-1:0]   fetch_addr,
    output logic              fetch_req,
    output logic              fetch_seq,
    output logic [1:0]        dbus_cyc,
    output logic              rf_rd_en,
    output logic              rf_rd_shift,
    output logic              rf_wr_en,
    output logic [REG_AW-1:0] rf_wr_addr,
    output logic              flush,
    output logic              exc_lock,
    output logic              busy
);

    seq_state_t state;
    seq_ctl_t   ctl;
    logic       cur_writes_pc;
    logic       cur_writes_gpr;
    logic       capture;
    logic       from_latch;

    assign capture    = (state == ST_EXEC) && issue_valid && shift_by_reg;
    assign from_latch = (state == ST_SHIFT2);

    seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .issue_valid  (issue_valid),
        .shift_by_reg (shift_by_reg),
        .cur_writes_pc(cur_writes_pc),
        .state        (state),
        .ctl          (ctl)
    );

    seq_rf_ctl #(.REG_AW(REG_AW), .PC_IDX(PC_IDX)) u_rf (
        .clk           (clk),
        .rst           (rst),
        .capture       (capture),
        .from_latch    (from_latch),
        .op_class      (op_class_t'(op_class)),
        .wr_result     (wr_result),
        .dest_reg      (dest_reg),
        .cur_writes_pc (cur_writes_pc),
        .cur_writes_gpr(cur_writes_gpr),
        .cur_dest      (rf_wr_addr)
    );

    seq_fetch_gen #(.XLEN(XLEN)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .sel       (ctl.sel),
        .half_width(half_width),
        .pc_in     (pc_in),
        .alu_result(alu_result),
        .fetch_addr(fetch_addr),
        .fetch_req (fetch_req),
        .fetch_seq (fetch_seq)
    );

    assign dbus_cyc    = BUS_IDLE;
    assign rf_rd_en    = ctl.rd_ops;
    assign rf_rd_shift = ctl.rd_shift;
    assign rf_wr_en    = ctl.wr_slot && cur_writes_gpr;
    assign flush       = ctl.flush;
    assign exc_lock    = ctl.exc_lock;
    assign busy        = ctl.busy;

endmodule

// File: rtl/dataop_seq_chk.sv
module dataop_seq_chk #(
    parameter int XLEN = 32
)(
    input logic            clk,
    input logic            rst,
    input logic            half_width,
    input logic [XLEN-1:0] alu_result,
    input logic [XLEN-1:0] fetch_addr,
    input logic            fetch_req,
    input logic            fetch_seq,
    input logic [1:0]      dbus_cyc,
    input logic            rf_wr_en,
    input logic            flush,
    input logic            exc_lock,
    input logic            busy
);

    AST_DBUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        dbus_cyc == 2'b00);  // R9

    AST_FLUSH_TARGET: assert property (@(posedge clk) disable iff (rst)
        flush |-> (fetch_req && !fetch_seq && fetch_addr == alu_result && !rf_wr_en));  // R6

    AST_REFILL_FIRST: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fetch_req && fetch_seq && busy && exc_lock && !flush
                   && fetch_addr == $past(alu_result) + ($past(half_width) ? 32'd2 : 32'd4)));  // R7

    AST_REFILL_LAST_LOCK: assert property (@(posedge clk) disable iff (rst)
        flush |=> ##1 (exc_lock && !busy && fetch_req && fetch_seq));  // R8

    AST_SHIFT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (busy && !exc_lock && fetch_req) |=> (!fetch_req || flush));  // R5

    AST_LOCK_ONLY_REFILL: assert property (@(posedge clk) disable iff (rst)
        (exc_lock && !busy) |=> !exc_lock);  // R8

endmodule

bind dataop_seq dataop_seq_chk #(.XLEN(XLEN)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .half_width(half_width),
    .alu_result(alu_result),
    .fetch_addr(fetch_addr),
    .fetch_req (fetch_req),
    .fetch_seq (fetch_seq),
    .dbus_cyc  (dbus_cyc),
    .rf_wr_en  (rf_wr_en),
    .flush     (flush),
    .exc_lock  (exc_lock),
    .busy      (busy)
);

// File: tb/test_dataop_seq.sv
`timescale 1ns/1ps
module test_dataop_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [1:0]  op_class;
    logic        shift_by_reg;
    logic [3:0]  dest_reg;
    logic        wr_result;
    logic        half_width;
    logic [31:0] pc_in;
    logic [31:0] alu_result;
    logic [31:0] fetch_addr;
    logic        fetch_req;
    logic        fetch_seq;
    logic [1:0]  dbus_cyc;
    logic        rf_rd_en;
    logic        rf_rd_shift;
    logic        rf_wr_en;
    logic [3:0]  rf_wr_addr;
    logic        flush;
    logic        exc_lock;
    logic        busy;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 0;

    always #2.5 clk = ~clk;

    dataop_seq i_dataop_seq (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .op_class(op_class),
        .shift_by_reg(shift_by_reg), .dest_reg(dest_reg), .wr_result(wr_result),
        .half_width(half_width), .pc_in(pc_in), .alu_result(alu_result),
        .fetch_addr(fetch_addr), .fetch_req(fetch_req), .fetch_seq(fetch_seq),
        .dbus_cyc(dbus_cyc), .rf_rd_en(rf_rd_en), .rf_rd_shift(rf_rd_shift),
        .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .flush(flush),
        .exc_lock(exc_lock), .busy(busy)
    );

    typedef struct packed {
        logic [1:0]  opc;
        logic [3:0]  dst;
        logic        wr;
        logic        half;
        logic [31:0] pc;
        logic [31:0] exp_fa;
        logic        exp_we;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 4'd3,  1'b1, 1'b0, 32'h0000_0100, 32'h0000_010C, 1'b1},
        '{2'b01, 4'd7,  1'b1, 1'b1, 32'h0000_0200, 32'h0000_0206, 1'b1},
        '{2'b10, 4'd2,  1'b1, 1'b0, 32'h0000_0300, 32'h0000_030C, 1'b0},
        '{2'b11, 4'd5,  1'b0, 1'b1, 32'h0000_0400, 32'h0000_0406, 1'b0},
        '{2'b00, 4'd0,  1'b0, 1'b0, 32'h0000_0500, 32'h0000_050C, 1'b0},
        '{2'b01, 4'd14, 1'b1, 1'b0, 32'hFFFF_FFF0, 32'hFFFF_FFFC, 1'b1},
        '{2'b00, 4'd1,  1'b1, 1'b1, 32'h0000_0010, 32'h0000_0016, 1'b1},
        '{2'b11, 4'd15, 1'b1, 1'b0, 32'h0000_0020, 32'h0000_002C, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] c, input logic s,
                         input logic [3:0] d, input logic w, input logic h,
                         input logic [31:0] pc, input logic [31:0] alu);
        @(negedge clk);
        issue_valid  = v;
        op_class     = c;
        shift_by_reg = s;
        dest_reg     = d;
        wr_result    = w;
        half_width   = h;
        pc_in        = pc;
        alu_result   = alu;
        #1;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        issue_valid = 0; op_class = 0; shift_by_reg = 0; dest_reg = 0;
        wr_result = 0; half_width = 0; pc_in = 0; alu_result = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state, nothing issued
        drive(0, 2'b00, 0, 4'd0, 0, 0, 32'h0, 32'h0);
        chk("R1", "busy", busy, 0);
        chk("R1", "flush", flush, 0);
        chk("R1", "exc_lock", exc_lock, 0);
        chk("R1", "fetch_req", fetch_req, 0);
        chk("R1", "rf_wr_en", rf_wr_en, 0);

        // R2 R3 R4 R9 single-cycle table
        for (int i = 0; i < NV; i++) begin
            drive(1, VECS[i].opc, 0, VECS[i].dst, VECS[i].wr, VECS[i].half,
                  VECS[i].pc, 32'hDEAD_0000);
            chk("R2", "fetch_addr", fetch_addr, VECS[i].exp_fa);
            chk("R2", "fetch_seq", fetch_seq, 1);
            chk("R2", "busy", busy, 0);
            chk("R4", "rf_wr_en", rf_wr_en, VECS[i].exp_we);
            chk("R4", "flush", flush, 0);
            chk("R9", "dbus_cyc", dbus_cyc, 0);
            if (VECS[i].exp_we) chk("R4", "rf_wr_addr", rf_wr_addr, VECS[i].dst);
        end

        // R5 register shift, 32-bit, arithmetic to r9
        drive(1, 2'b00, 1, 4'd9, 1, 0, 32'h0000_1000, 32'h0);
        chk("R5", "c1 fetch_addr", fetch_addr, 32'h0000_100C);
        chk("R5", "c1 fetch_seq", fetch_seq, 1);
        chk("R5", "c1 busy", busy, 1);
        chk("R5", "c1 rf_wr_en", rf_wr_en, 0);
        drive(0, 2'b10, 0, 4'd0, 0, 0, 32'h0000_1004, 32'h0);
        chk("R5", "c2 fetch_req", fetch_req, 0);
        chk("R5", "c2 rf_rd_shift", rf_rd_shift, 1);
        chk("R5", "c2 busy", busy, 0);
        chk("R5", "c2 rf_wr_en", rf_wr_en, 1);
        chk("R5", "c2 rf_wr_addr", rf_wr_addr, 4'd9);

        // R4 R5 register-shifted compare writes nothing
        drive(1, 2'b10, 1, 4'd3, 1, 1, 32'h0000_2000, 32'h0);
        chk("R3", "c1 fetch_addr", fetch_addr, 32'h0000_2006);
        drive(0, 2'b00, 0, 4'd3, 1, 1, 32'h0000_2002, 32'h0);
        chk("R4", "c2 rf_wr_en", rf_wr_en, 0);
        chk("R4", "c2 flush", flush, 0);

        // R6 R7 R8 program counter destination, 32-bit
        drive(1, 2'b01, 0, 4'd15, 1, 0, 32'h0000_3000, 32'h0000_8000);
        chk("R6", "flush", flush, 1);
        chk("R6", "fetch_addr", fetch_addr, 32'h0000_8000);
        chk("R6", "fetch_seq", fetch_seq, 0);
        chk("R6", "rf_wr_en", rf_wr_en, 0);
        chk("R8", "lock c1", exc_lock, 1);
        drive(1, 2'b00, 0, 4'd4, 1, 0, 32'h0000_3004, 32'h0000_1111);
        chk("R7", "r1 fetch_addr", fetch_addr, 32'h0000_8004);
        chk("R7", "r1 fetch_seq", fetch_seq, 1);
        chk("R7", "r1 busy", busy, 1);
        chk("R7", "r1 ignored write", rf_wr_en, 0);
        chk("R8", "lock r1", exc_lock, 1);
        drive(1, 2'b00, 0, 4'd4, 1, 0, 32'h0000_3008, 32'h0000_2222);
        chk("R7", "r2 fetch_addr", fetch_addr, 32'h0000_8008);
        chk("R7", "r2 busy", busy, 0);
        chk("R7", "r2 ignored write", rf_wr_en, 0);
        chk("R8", "lock r2", exc_lock, 1);
        drive(0, 2'b00, 0, 4'd0, 0, 0, 32'h0000_8000, 32'h0);
        chk("R8", "lock after", exc_lock, 0);
        chk("R8", "fetch_req after", fetch_req, 0);

        // R3 R7 program counter destination, 16-bit
        drive(1, 2'b00, 0, 4'd15, 1, 1, 32'h0000_4000, 32'h0000_A000);
        chk("R6", "half flush", flush, 1);
        drive(0, 2'b00, 0, 4'd0, 0, 1, 32'h0, 32'h0);
        chk("R3", "half r1", fetch_addr, 32'h0000_A002);
        drive(0, 2'b00, 0, 4'd0, 0, 1, 32'h0, 32'h0);
        chk("R3", "half r2", fetch_addr, 32'h0000_A004);

        // R10 register shift with program counter destination
        drive(1, 2'b00, 1, 4'd15, 1, 0, 32'h0000_5000, 32'h0000_0BAD);
        chk("R10", "c1 flush", flush, 0);
        chk("R10", "c1 fetch_addr", fetch_addr, 32'h0000_500C);
        chk("R10", "c1 lock", exc_lock, 0);
        drive(0, 2'b00, 0, 4'd0, 0, 0, 32'h0000_5004, 32'h0000_C000);
        chk("R10", "c2 flush", flush, 1);
        chk("R10", "c2 fetch_addr", fetch_addr, 32'h0000_C000);
        chk("R10", "c2 fetch_seq", fetch_seq, 0);
        drive(0, 2'b00, 0, 4'd0, 0, 0, 32'h0, 32'h0);
        chk("R10", "r1 fetch_addr", fetch_addr, 32'h0000_C004);
        drive(0, 2'b00, 0, 4'd0, 0, 0, 32'h0, 32'h0);
        chk("R10", "r2 fetch_addr", fetch_addr, 32'h0000_C008);
        drive(0, 2'b00, 0, 4'd0, 0, 0, 32'h0, 32'h0);
        chk("R1", "idle busy", busy, 0);

        done = 1;
        finish_run();
    end

endmodule